// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block keeps two usage flags for each of eight resident page frames. One flag records that the frame was touched since the last sweep. The other records that the frame was written since it was loaded. When the replacement logic asks for a frame to evict, the block ranks every frame by its pair of flags. It then nominates one frame from the least valuable group. Along with the frame it reports whether the old contents must be saved before the frame is reused.

Frames that hold no page are always handed out first. Among equally ranked frames, a free-running pseudo-random sequence chooses a start position, and the scan moves upward from there. This spreads evictions across the group. The block moves no page contents and edits no page table.

The select path is a plain request/response pair with a fixed one-cycle latency. There is no back-pressure: each request cycle yields exactly one response cycle, so the consumer must accept a result in the cycle it appears. Requests may be issued on consecutive cycles.

Top module: `nru_victim_sel`

## Requirements
- R1: A cycle with `ref_valid` high sets the touched flag of frame `ref_frame`. If `ref_write` is also high, the same cycle sets that frame's written flag. Both flags are visible to selection from the next cycle on.
- R2: A cycle with `clr_pulse` high zeroes every touched flag and leaves every written flag unchanged. A reference in that same cycle still sets the flags of its frame.
- R3: A cycle with `load_valid` high zeroes both flags of frame `load_frame`. This overrides a reference to the same frame in that cycle.
- R4: A frame whose bit in `occ_mask` is 0 is empty. If any frame is empty, the victim is an empty frame and `victim_dirty` is 0.
- R5: An occupied frame's rank is 2*touched + written: 0 = untouched clean, 1 = untouched written, 2 = touched clean, 3 = touched written. With no empty frame, the victim comes from the lowest rank that has at least one frame.
- R6: Within the chosen group, the victim is the first member found scanning frame indices upward from the start index, wrapping from 7 to 0.
- R7: The start index is bits [2:0] of a 16-bit shift register. On reset it is 16'hACE1. Every clock after reset it shifts left by one, taking in the XOR of bits 15, 13, 12 and 10. The value used is the one held during the request cycle.
- R8: `victim_dirty` equals the written flag of the chosen frame when that frame is occupied.
- R9: `victim_valid` is high in exactly the cycle after each cycle with `sel_req` high, and low otherwise. The result is based on the flags, mask and shift register as they stood in the request cycle, before that cycle's updates.
- R10: After reset, all flags are zero and `victim_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A frame was accessed this cycle |
| ref_frame | input | 3 | Index of the accessed frame |
| ref_write | input | 1 | The access was a write |
| clr_pulse | input | 1 | Periodic sweep: forget touched flags |
| load_valid | input | 1 | A new page was placed in a frame |
| load_frame | input | 3 | Index of the reloaded frame |
| occ_mask | input | 8 | One bit per frame, 1 = holds a page |
| sel_req | input | 1 | Request a victim |
| victim_valid | output | 1 | Result strobe, one cycle after request |
| victim_frame | output | 3 | Chosen frame |
| victim_dirty | output | 1 | Chosen frame must be written back |

## Verification
A stuck or lost flag bit shows up as a victim from the wrong rank, or as a wrong dirty indication. It appears on the first request after the faulty update, one cycle after that request. A wrong scan start or shift-register step shows up as a different frame within the correct group. Because the pseudo-random sequence starts in a known state, this is visible on the very first request after reset. The bench compares every response against an independent model, under empty, mixed-rank, swept and reloaded states, including back-to-back requests.

// File: rtl/nru_pkg.sv
package nru_pkg;
  localparam int unsigned LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam int unsigned N_RANKS   = 4;

  function automatic logic lfsr_fb(input logic [15:0] s);
    return s[15] ^ s[13] ^ s[12] ^ s[10];
  endfunction
endpackage

// File: rtl/nru_flag_bank.sv
module nru_flag_bank #(
  parameter int unsigned N_FRAMES = 8,
  localparam int unsigned IW = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_valid,
  input  logic [IW-1:0]       ref_frame,
  input  logic                ref_write,
  input  logic                clr_pulse,
  input  logic                load_valid,
  input  logic [IW-1:0]       load_frame,
  output logic [N_FRAMES-1:0] ref_bits,
  output logic [N_FRAMES-1:0] mod_bits
);
  for (genvar f = 0; f < N_FRAMES; f++) begin : g_frame
    logic hit_ref, hit_load;
    assign hit_ref  = ref_valid  && (ref_frame  == IW'(f));
    assign hit_load = load_valid && (load_frame == IW'(f));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_bits[f] <= 1'b0;
        mod_bits[f] <= 1'b0;
      end else if (hit_load) begin
        ref_bits[f] <= 1'b0;
        mod_bits[f] <= 1'b0;
      end else begin
        if (hit_ref)        ref_bits[f] <= 1'b1;
        else if (clr_pulse) ref_bits[f] <= 1'b0;
        if (hit_ref && ref_write) mod_bits[f] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nru_lfsr.sv
module nru_lfsr
  import nru_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= {state[LFSR_W-2:0], lfsr_fb(state)};
  end
endmodule

// File: rtl/nru_rot_pick.sv
module nru_rot_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] start,
  output logic [IW-1:0] idx,
  output logic          hit
);
  always_comb begin
    idx = start;
    hit = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (cand[(int'(start) + k) % N]) begin
        idx = IW'((int'(start) + k) % N);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
  import nru_pkg::*;
#(
  parameter int unsigned N_FRAMES = 8,
  localparam int unsigned IW = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_valid,
  input  logic [IW-1:0]       ref_frame,
  input  logic                ref_write,
  input  logic                clr_pulse,
  input  logic                load_valid,
  input  logic [IW-1:0]       load_frame,
  input  logic [N_FRAMES-1:0] occ_mask,
  input  logic                sel_req,
  output logic                victim_valid,
  output logic [IW-1:0]       victim_frame,
  output logic                victim_dirty
);
  logic [N_FRAMES-1:0] ref_bits, mod_bits;
  logic [LFSR_W-1:0]   lfsr_q;
  logic [N_FRAMES-1:0] rank_set [N_RANKS];
  logic [N_FRAMES-1:0] empty_set, cand;
  logic [IW-1:0]       pick_idx;
  logic                pick_hit;

  nru_flag_bank #(.N_FRAMES(N_FRAMES)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
    .clr_pulse(clr_pulse),
    .load_valid(load_valid), .load_frame(load_frame),
    .ref_bits(ref_bits), .mod_bits(mod_bits)
  );

  nru_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_q));

  assign empty_set = ~occ_mask;

  for (genvar r = 0; r < N_RANKS; r++) begin : g_rank
    for (genvar f = 0; f < N_FRAMES; f++) begin : g_f
      assign rank_set[r][f] = occ_mask[f] && ({ref_bits[f], mod_bits[f]} == 2'(r));
    end
  end

  always_comb begin
    cand = '0;
    for (int r = N_RANKS - 1; r >= 0; r--) begin
      if (|rank_set[r]) cand = rank_set[r];
    end
    if (|empty_set) cand = empty_set;
  end

  nru_rot_pick #(.N(N_FRAMES)) u_pick (
    .cand(cand), .start(lfsr_q[IW-1:0]), .idx(pick_idx), .hit(pick_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_valid <= 1'b0;
      victim_frame <= '0;
      victim_dirty <= 1'b0;
    end else begin
      victim_valid <= sel_req;
      if (sel_req) begin
        victim_frame <= pick_idx;
        victim_dirty <= pick_hit && occ_mask[pick_idx] && mod_bits[pick_idx];
      end
    end
  end
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
  parameter int unsigned N_FRAMES = 8,
  localparam int unsigned IW = $clog2(N_FRAMES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_valid,
  input logic [IW-1:0]       ref_frame,
  input logic                ref_write,
  input logic                clr_pulse,
  input logic                load_valid,
  input logic [N_FRAMES-1:0] occ_mask,
  input logic                sel_req,
  input logic                victim_valid,
  input logic [IW-1:0]       victim_frame,
  input logic                victim_dirty,
  input logic [N_FRAMES-1:0] ref_bits,
  input logic [N_FRAMES-1:0] mod_bits
);
  logic [N_FRAMES-1:0] occ_q;
  always_ff @(posedge clk) occ_q <= occ_mask;

  // R9
  answer_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |=> victim_valid);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_req |=> !victim_valid);
  // R4
  empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && !(&occ_mask)) |=> (!victim_dirty && !occ_q[victim_frame]));
  // R2
  sweep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !ref_valid) |=> (ref_bits == '0));
  // R2
  sweep_keeps_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !ref_valid && !load_valid) |=> (mod_bits == $past(mod_bits)));
  // R1
  write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_write && !load_valid) |=> (mod_bits[$past(ref_frame)] && ref_bits[$past(ref_frame)]));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.N_FRAMES(N_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
  .clr_pulse(clr_pulse), .load_valid(load_valid), .occ_mask(occ_mask),
  .sel_req(sel_req), .victim_valid(victim_valid),
  .victim_frame(victim_frame), .victim_dirty(victim_dirty),
  .ref_bits(ref_bits), .mod_bits(mod_bits)
);

// File: tb/tb_nru_victim_sel.sv
`timescale 1ns/1ps
module tb_nru_victim_sel;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ref_valid, ref_write, clr_pulse, load_valid, sel_req;
  logic [2:0] ref_frame, load_frame;
  logic [N-1:0] occ_mask;
  logic victim_valid, victim_dirty;
  logic [2:0] victim_frame;

  nru_victim_sel dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .ref_write(ref_write), .clr_pulse(clr_pulse), .load_valid(load_valid),
    .load_frame(load_frame), .occ_mask(occ_mask), .sel_req(sel_req),
    .victim_valid(victim_valid), .victim_frame(victim_frame),
    .victim_dirty(victim_dirty)
  );

  int checks = 0, errors = 0;

  // Reference model built from the requirements
  logic [N-1:0] mr, mm;
  logic [15:0]  ml;
  always @(posedge clk) begin
    if (!rst_n) begin
      mr <= '0; mm <= '0; ml <= 16'hACE1;
    end else begin
      logic [N-1:0] nr, nm;
      nr = mr; nm = mm;
      if (clr_pulse) nr = '0;
      if (ref_valid) begin
        nr[ref_frame] = 1'b1;
        if (ref_write) nm[ref_frame] = 1'b1;
      end
      if (load_valid) begin
        nr[load_frame] = 1'b0;
        nm[load_frame] = 1'b0;
      end
      mr <= nr; mm <= nm;
      ml <= {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
    end
  end

  typedef struct { logic [2:0] f; logic d; string tag; } exp_t;
  exp_t q[$];

  function automatic exp_t predict(string tag);
    exp_t e;
    logic [N-1:0] c;
    c = ~occ_mask;
    if (c == '0) begin
      for (int r = 3; r >= 0; r--) begin
        logic [N-1:0] s;
        for (int f = 0; f < N; f++) s[f] = occ_mask[f] && ({mr[f], mm[f]} == 2'(r));
        if (s != '0) c = s;
      end
    end
    e.f = 3'd0;
    for (int k = N - 1; k >= 0; k--)
      if (c[(int'(ml[2:0]) + k) % N]) e.f = 3'((int'(ml[2:0]) + k) % N);
    e.d = occ_mask[e.f] && mm[e.f];
    e.tag = tag;
    return e;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Driver: pushes expectation, pulses the request
  task automatic do_select(string tag);
    q.push_back(predict(tag));
    sel_req = 1'b1;
    @(negedge clk);
    sel_req = 1'b0;
  endtask

  task automatic do_ref(int f, bit w);
    ref_valid = 1'b1; ref_frame = 3'(f); ref_write = w;
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
  endtask

  task automatic do_load(int f);
    load_valid = 1'b1; load_frame = 3'(f);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  // Monitor: pops and compares each response
  always @(negedge clk) begin
    if (rst_n && victim_valid) begin
      if (q.size() == 0) begin
        check("R9 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " frame"}, 32'(victim_frame), 32'(e.f));
        check({e.tag, " dirty R8"}, 32'(victim_dirty), 32'(e.d));
      end
    end
  end

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ref_valid = 0; ref_write = 0; clr_pulse = 0; load_valid = 0;
    sel_req = 0; ref_frame = 0; load_frame = 0; occ_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 valid low after reset", 32'(victim_valid), 0);
    @(negedge clk);
    check("R9 no response without request", 32'(victim_valid), 0);

    // All empty: scan start comes straight from the seeded register
    do_select("R7 R4 all empty");
    do_select("R7 R6 all empty second");

    occ_mask = 8'b1011_0110;
    do_select("R4 partial occupancy");

    occ_mask = 8'hFF;
    do_select("R5 R6 all rank 0");

    do_ref(0, 0); do_ref(1, 1); do_ref(2, 1); do_ref(3, 0);
    do_ref(4, 0); do_ref(5, 1); do_ref(6, 0); do_ref(7, 1);
    do_select("R1 R5 rank 2 chosen");
    do_select("R5 rank 2 repeat");

    clr_pulse = 1'b1; @(negedge clk); clr_pulse = 1'b0;
    do_select("R2 sweep gives rank 0");
    do_ref(0, 0); do_ref(3, 0); do_ref(4, 0); do_ref(6, 0);
    do_select("R2 R8 written survives sweep");

    do_load(5);
    do_select("R3 reloaded frame clean");
    load_valid = 1'b1; load_frame = 3'd2;
    ref_valid = 1'b1; ref_frame = 3'd2; ref_write = 1'b1;
    @(negedge clk);
    load_valid = 1'b0; ref_valid = 1'b0; ref_write = 1'b0;
    do_select("R3 load beats reference");

    clr_pulse = 1'b1; ref_valid = 1'b1; ref_frame = 3'd5; ref_write = 1'b0;
    @(negedge clk);
    clr_pulse = 1'b0; ref_valid = 1'b0;
    do_select("R2 reference during sweep");

    occ_mask = 8'b0111_1111;
    do_select("R4 one empty frame");
    occ_mask = 8'hFF;

    // Back-to-back requests with traffic in the same cycles
    for (int i = 0; i < 6; i++) begin
      q.push_back(predict("R9 back-to-back"));
      sel_req = 1'b1;
      ref_valid = 1'b1; ref_frame = 3'(i); ref_write = (i % 2 == 1);
      @(negedge clk);
    end
    sel_req = 1'b0; ref_valid = 1'b0; ref_write = 1'b0;

    // Mixed traffic
    for (int i = 0; i < 60; i++) begin
      ref_valid  = ($urandom % 2) == 1;
      ref_frame  = 3'($urandom % 8);
      ref_write  = ($urandom % 3) == 0;
      clr_pulse  = ($urandom % 7) == 0;
      load_valid = ($urandom % 5) == 0;
      load_frame = 3'($urandom % 8);
      occ_mask   = (($urandom % 4) == 0) ? 8'($urandom) : 8'hFF;
      if (($urandom % 2) == 1) begin
        q.push_back(predict("R5 R6 mixed traffic"));
        sel_req = 1'b1;
      end
      @(negedge clk);
      sel_req = 1'b0;
    end
    ref_valid = 0; clr_pulse = 0; load_valid = 0;

    repeat (3) @(negedge clk);
    check("R9 every request answered", 32'(q.size()), 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule